// File: doc/BRIEF.md
# Link power status interface controller

This block sits between a link-layer power-status pin and the PHY-to-link interface. The pin is first passed through a two-flop synchronizer. A counter then measures how long it has stayed low, and the result decides how much of the interface stays powered. A short low dip changes nothing. A low lasting past a first threshold puts the interface into a low-power reset state. In that state the control/data drivers are forced to zero and link requests are ignored, but the interface clock keeps running. A low lasting past a second, longer threshold also stops the interface clock.

When the pin is seen high again, the block spends one cycle initializing the interface and then returns to normal operation. If the low period reached the deeper threshold, a bus-reset request is pulsed in that same cycle, so the rest of the bus learns that the link is reachable again. A hardware reset holds the interface in the deepest state. Only the status pin steers the state; no register bit of the link takes part.

Top module: `lps_link_gate`

## Requirements
- R1: `lps_active` is 0 only while the synchronized pin has been sampled low on at least `RST_CYC` consecutive cycles; a single high sample restarts the count. With the pin driven low just after a clock edge, `lps_active` is still 1 after RST_CYC+1 further edges and 0 after RST_CYC+2.
- R2: In the low-power reset state `xfer_en` is 0 and `pclk_en` is 1. The state is entered one edge after `lps_active` falls (RST_CYC+3 edges after the pin drop).
- R3: When the low count reaches `DIS_CYC`, the interface enters the disabled state with `pclk_en` = 0, at DIS_CYC+3 edges after the pin drop. `xfer_en` = 1 never occurs while `pclk_en` = 0.
- R4: On the pin returning high from the reset or disabled state, `iface_init` is 1 for exactly one cycle, on the third edge after the pin rises. `xfer_en` becomes 1 on the next edge.
- R5: `bus_reset_req` pulses for one cycle together with `iface_init`, only if the disabled state was reached from operation. A return from the reset state alone gives no pulse.
- R6: While `rst_n` is 0, `pclk_en` = 0, `xfer_en` = 0 and `lps_active` = 0. After release with the pin high, the interface initializes without a bus-reset request.
- R7: A low pulse of at most RST_CYC cycles leaves `xfer_en` and `pclk_en` at 1 and produces no `iface_init`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| lps_in | input | 1 | Link power status pin, asynchronous |
| lps_active | output | 1 | Debounced status: 1 unless low past RST_CYC |
| xfer_en | output | 1 | Enables control/data drivers and link request acceptance |
| pclk_en | output | 1 | Enables the interface clock output |
| iface_init | output | 1 | One-cycle interface initialization pulse |
| bus_reset_req | output | 1 | One-cycle bus-reset request |

## Verification
The hardest case is the boundary around each threshold. The synchronizer and the counter both delay the pin, so a low pulse of exactly RST_CYC cycles ends just as the count would have reached the threshold. One cycle more is enough to enter the reset state. The same holds for a pulse of DIS_CYC against DIS_CYC+1 cycles, which separates a plain reset-state return from a return that requests a bus reset. The stimulus table therefore places low pulses on both sides of each threshold. A directed run then counts edges from a single pin drop and samples each output on the exact edges where it must still hold and where it must change.

// File: rtl/lps_link_gate.sv
module lps_link_gate #(
  parameter int RST_CYC = 64,
  parameter int DIS_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lps_in,
  output logic lps_active,
  output logic xfer_en,
  output logic pclk_en,
  output logic iface_init,
  output logic bus_reset_req
);
  localparam int CW = $clog2(DIS_CYC + 1);
  localparam logic [CW-1:0] RST_LIM = CW'(RST_CYC);
  localparam logic [CW-1:0] DIS_LIM = CW'(DIS_CYC);

  typedef enum logic [1:0] {ST_RUN, ST_RST, ST_DIS, ST_INIT} st_t;

  st_t state;
  logic s1, s2, deep;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= lps_in;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             low_cnt <= DIS_LIM;
    else if (s2)            low_cnt <= '0;
    else if (low_cnt != DIS_LIM) low_cnt <= low_cnt + 1'b1;

  assign lps_active = s2 || (low_cnt < RST_LIM);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= ST_DIS;
      deep  <= 1'b0;
    end else begin
      case (state)
        ST_RUN, ST_RST:
          if (state == ST_RST && lps_active) state <= ST_INIT;
          else if (low_cnt == DIS_LIM) begin
            state <= ST_DIS;
            deep  <= 1'b1;
          end else if (!lps_active) state <= ST_RST;
        ST_DIS:
          if (lps_active) state <= ST_INIT;
        default: begin
          state <= ST_RUN;
          deep  <= 1'b0;
        end
      endcase
    end

  assign xfer_en       = (state == ST_RUN);
  assign pclk_en       = (state != ST_DIS);
  assign iface_init    = (state == ST_INIT);
  assign bus_reset_req = (state == ST_INIT) && deep;
endmodule

module lps_link_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic lps_active,
  input logic xfer_en,
  input logic pclk_en,
  input logic iface_init,
  input logic bus_reset_req
);
  a_r4_init_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    iface_init |=> !iface_init);
  a_r4_run_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    iface_init |=> xfer_en);
  a_r5_busrst_with_init: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_req |-> iface_init);
  a_r3_no_xfer_without_clk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en |-> pclk_en);
  a_r2_drop_needs_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xfer_en) |-> !$past(lps_active));
  a_r6_clk_back_with_init: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pclk_en) |-> iface_init);
endmodule

bind lps_link_gate lps_link_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lps_active(lps_active), .xfer_en(xfer_en),
  .pclk_en(pclk_en), .iface_init(iface_init), .bus_reset_req(bus_reset_req)
);

// File: tb/sim_lps_link_gate.sv
module sim_lps_link_gate;
  localparam int RST = 8;
  localparam int DIS = 32;

  logic clk = 1'b0, rst_n = 1'b0, lps_in = 1'b1;
  logic lps_active, xfer_en, pclk_en, iface_init, bus_reset_req;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  lps_link_gate #(.RST_CYC(RST), .DIS_CYC(DIS)) u0 (
    .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .lps_active(lps_active),
    .xfer_en(xfer_en), .pclk_en(pclk_en), .iface_init(iface_init),
    .bus_reset_req(bus_reset_req));

  // low length, inits, bus resets, pclk dropped, xfer dropped
  localparam int VEC [0:6][0:4] = '{
    '{3,        0, 0, 0, 0},
    '{RST,      0, 0, 0, 0},
    '{RST + 1,  1, 0, 0, 1},
    '{20,       1, 0, 0, 1},
    '{DIS,      1, 0, 0, 1},
    '{DIS + 1,  1, 1, 1, 1},
    '{60,       1, 1, 1, 1}
  };

  logic mon_clr = 1'b0;
  int n_init = 0, n_br = 0;
  logic pdrop = 1'b0, xdrop = 1'b0;
  always @(negedge clk)
    if (mon_clr) begin
      n_init = 0; n_br = 0; pdrop = 1'b0; xdrop = 1'b0;
    end else begin
      if (iface_init) n_init++;
      if (bus_reset_req) n_br++;
      if (!pclk_en) pdrop = 1'b1;
      if (!xfer_en) xdrop = 1'b1;
    end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R6 pclk_en in reset", pclk_en, 0);
    chk("R6 xfer_en in reset", xfer_en, 0);
    chk("R6 lps_active in reset", lps_active, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 init after reset", iface_init, 1);
    chk("R6 no bus reset after hw reset", bus_reset_req, 0);
    @(negedge clk);
    chk("R4 running after init", xfer_en, 1);

    for (int i = 0; i < 7; i++) begin
      mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
      lps_in = 1'b0;
      repeat (VEC[i][0]) @(negedge clk);
      lps_in = 1'b1;
      repeat (12) @(negedge clk);
      chk("R4 R7 init count", n_init, VEC[i][1]);
      chk("R5 bus reset count", n_br, VEC[i][2]);
      chk("R3 R7 pclk dropped", int'(pdrop), VEC[i][3]);
      chk("R2 R7 xfer dropped", int'(xdrop), VEC[i][4]);
      chk("R4 back to normal", xfer_en, 1);
    end

    lps_in = 1'b0;
    repeat (RST + 1) @(negedge clk);
    chk("R1 still active", lps_active, 1);
    @(negedge clk);
    chk("R1 inactive at threshold", lps_active, 0);
    chk("R2 xfer_en one edge later", xfer_en, 1);
    @(negedge clk);
    chk("R2 xfer_en gated", xfer_en, 0);
    chk("R2 pclk_en kept", pclk_en, 1);
    repeat (DIS - RST - 1) @(negedge clk);
    chk("R3 pclk before disable", pclk_en, 1);
    @(negedge clk);
    chk("R3 pclk gated", pclk_en, 0);
    lps_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 no early init", iface_init, 0);
    @(negedge clk);
    chk("R4 init pulse", iface_init, 1);
    chk("R5 bus reset with init", bus_reset_req, 1);
    chk("R4 pclk back during init", pclk_en, 1);
    @(negedge clk);
    chk("R4 init single cycle", iface_init, 0);
    chk("R5 bus reset single cycle", bus_reset_req, 0);
    chk("R4 xfer_en restored", xfer_en, 1);

    rst_n = 1'b0;
    #1;
    chk("R6 hw reset gates pclk", pclk_en, 0);
    chk("R6 hw reset gates xfer", xfer_en, 0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
    repeat (6) @(negedge clk);
    chk("R6 single init after release", n_init, 1);
    chk("R6 no bus reset after release", n_br, 0);
    chk("R6 running after release", xfer_en, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule